// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Protocol Engine

This block is the protocol core of a two-wire serial EEPROM slave. It takes SCL and SDA levels that a front end has already filtered and synchronised to the system clock, together with one-cycle start and stop strobes. It drives a single open-drain enable that pulls SDA low. The engine checks the device address byte and then takes a two-byte word address. Write data goes into a page buffer. Read data comes from a synchronous byte array through a shared address pointer.

A stop that ends a write transaction commits the page buffer. The buffer is drained into the array, and a one-cycle pulse starts an external write timer. While that timer's busy flag is high, or while the drain is still running, the engine acknowledges nothing. A master can therefore poll for completion by sending the device address repeatedly. A write-protect input can veto the commit of a whole transaction. A selection strap sets one bit of the device address. The array depth is a parameter: the full-size part uses 13 address bits (8K by 8) and the default build uses 11.

Top module: `eep_slave_engine`

## Requirements
- R1: The device address byte is received MSB first. It is acknowledged (SDA pulled low during the 9th clock) only when its upper seven bits equal 1010, then the strap value, then 0, 0. Bit 0 selects read (1) or write (0). On a mismatch, no ACK is given and nothing more is acknowledged until the next start.
- R2: After a write-direction address, two word-address bytes follow, high byte first, and each is acknowledged. The pointer takes the low ADDR_W bits of the 13-bit address formed by the high byte's bits 4..0 and the low byte. All higher bits are ignored.
- R3: Input bits are sampled on SCL rising edges. The SDA enable changes only while SCL is low, so a driven bit stays stable for the whole SCL high phase.
- R4: Write data bytes are each acknowledged. They land at successive offsets within the 32-byte page of the pointer, and the offset wraps inside the page. A later byte at the same offset replaces an earlier one. Afterwards, the pointer holds the next offset in the same page.
- R5: A stop that follows at least one write data byte pulses wr_go_o for one cycle, provided write protect was never seen high. The buffered bytes then appear in the array.
- R6: While busy_i is high or the buffer is still draining, a matching device address gets no ACK, whatever its R/W bit. Once both are clear, the same address is acknowledged.
- R7: A read-direction address returns data starting at the pointer. A stop right after the two word-address bytes loads the pointer without any commit, and so does a repeated start at that point.
- R8: After each read byte, the pointer advances and wraps from the top of the array to 0. A master ACK fetches the next byte. A master NACK releases SDA, and the engine idles until the next start.
- R9: If write protect is high at any SCL rising edge of a write transaction, the stop does not commit (no wr_go_o, array unchanged). Data bytes are still acknowledged and the pointer still advances.
- R10: A start, nine clocks with SDA released, and another start leave the engine ready for a new device address, with the pointer unchanged.
- R11: After reset, the SDA enable and wr_go_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Filtered, synchronised SCL level |
| sda_i | input | 1 | Filtered, synchronised SDA level (wired bus value) |
| start_i | input | 1 | One-cycle strobe marking a start condition |
| stop_i | input | 1 | One-cycle strobe marking a stop condition |
| wp_i | input | 1 | Write protect, high blocks the commit |
| sel_i | input | 1 | Strap for device address bit 3 |
| busy_i | input | 1 | High while the external write timer runs |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| wr_go_o | output | 1 | One-cycle pulse starting the write timer |

## Verification
A wrong bit counter or state shows at the ports within one byte. The ACK either appears in the wrong SCL period or is missing on the next 9th clock, and read data arrives shifted. A wrong pointer or page offset shows only later: the next current-address or sequential read returns a byte from the wrong location, which the bench catches by comparing every read against its own model. A broken protect flag or busy gate shows as an extra or missing wr_go_o pulse, or as an ACK during polling, within a few cycles of the stop.

// File: rtl/eep_pkg.sv
// Package: shared types and constants for the serial EEPROM slave engine.
// Assumes: one byte per transfer, MSB first, 9 clocks per byte.
package eep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DEV   = 3'd1,
        ST_AHI   = 3'd2,
        ST_ALO   = 3'd3,
        ST_WDATA = 3'd4,
        ST_RDATA = 3'd5
    } eep_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_array.sv
// Module: byte-wide synchronous RAM standing in for the storage array.
// One write port (fed by the page-buffer drain) and one registered read
// port that always presents the byte at raddr_i one cycle later.
// Assumes: no contents are guaranteed before they are written.
module eep_array #(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    logic [7:0] mem [DEPTH];

    // Write port, then registered read of the current pointer.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/eep_page_buf.sv
// Module: page buffer collecting write bytes for one page.
// Bytes arrive by page offset with a valid mask. On commit, every offset is
// visited once (one per cycle) and valid bytes are written to the array.
// Assumes: no fill happens while draining (the protocol engine is gated
// by busy during the drain).
module eep_page_buf #(
    parameter int ADDR_W = 11,
    parameter int PAGE   = 32,
    localparam int OFF_W = $clog2(PAGE),
    localparam int BASE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [7:0]        data_i,
    input  logic              clear_i,
    input  logic              commit_i,
    input  logic [BASE_W-1:0] base_i,
    output logic              draining_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o
);
    logic [7:0]        slot [PAGE];
    logic [PAGE-1:0]   valid;
    logic [OFF_W-1:0]  idx;
    logic [BASE_W-1:0] base;
    logic              draining;

    // Byte storage: written by the protocol engine at the given offset.
    always_ff @(posedge clk) begin
        if (we_i) begin
            slot[off_i] <= data_i;
        end
    end

    // Valid mask and drain sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= '0;
            idx      <= '0;
            base     <= '0;
            draining <= 1'b0;
        end else if (commit_i) begin
            draining <= 1'b1;
            idx      <= '0;
            base     <= base_i;
        end else if (draining) begin
            idx <= idx + OFF_W'(1);
            if (idx == OFF_W'(PAGE - 1)) begin
                draining <= 1'b0;
                valid    <= '0;
            end
        end else if (clear_i) begin
            valid <= '0;
        end else if (we_i) begin
            valid[off_i] <= 1'b1;
        end
    end

    assign draining_o = draining;
    assign mem_we_o   = draining & valid[idx];
    assign mem_addr_o = {base, idx};
    assign mem_data_o = slot[idx];

    // R5
    no_fill_while_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> !draining);

    // R5
    commit_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !draining);
endmodule

// File: rtl/eep_proto.sv
// Module: bit/byte protocol state machine of the EEPROM slave.
// Detects SCL edges, shifts bits in on rising edges, and updates the
// SDA drive only after falling edges. Decodes device address, word
// address, write data and read data, and owns the address pointer.
// Assumes: scl_i/sda_i are clean synchronous levels; start_i/stop_i are
// one-cycle strobes produced while SCL is high.
module eep_proto
    import eep_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE   = 32,
    localparam int OFF_W = $clog2(PAGE),
    localparam int BASE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              wp_i,
    input  logic              sel_i,
    input  logic              busy_i,
    input  logic [7:0]        rd_q_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              buf_we_o,
    output logic [OFF_W-1:0]  buf_off_o,
    output logic [7:0]        buf_data_o,
    output logic              buf_clear_o,
    output logic              commit_o,
    output logic [BASE_W-1:0] commit_base_o,
    output logic              sda_oe_o
);
    eep_state_t        st, nxt;
    logic              scl_q;
    logic              rise, fall;
    logic [3:0]        bcnt;
    logic              ack_ph;
    logic [7:0]        sh;
    logic              drive;
    logic              mack;
    logic [4:0]        hi;
    logic [ADDR_W-1:0] ptr;
    logic              data_seen;
    logic              wp_seen;
    logic              addr_match;

    // Previous SCL level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_i;
    end

    assign rise = scl_i & ~scl_q;
    assign fall = ~scl_i & scl_q;
    assign addr_match = (sh[7:1] == {DEV_CODE, sel_i, 2'b00});

    // Main protocol sequencer: conditions first, then rising, then falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            nxt         <= ST_IDLE;
            bcnt        <= '0;
            ack_ph      <= 1'b0;
            sh          <= '0;
            drive       <= 1'b0;
            mack        <= 1'b0;
            hi          <= '0;
            ptr         <= '0;
            data_seen   <= 1'b0;
            wp_seen     <= 1'b0;
            buf_we_o    <= 1'b0;
            buf_off_o   <= '0;
            buf_data_o  <= '0;
            buf_clear_o <= 1'b0;
            commit_o    <= 1'b0;
        end else begin
            buf_we_o    <= 1'b0;
            buf_clear_o <= 1'b0;
            commit_o    <= 1'b0;
            if (start_i) begin
                st      <= ST_DEV;
                bcnt    <= '0;
                ack_ph  <= 1'b0;
                drive   <= 1'b0;
                wp_seen <= 1'b0;
            end else if (stop_i) begin
                if (st == ST_WDATA && data_seen) begin
                    if (!wp_seen) commit_o    <= 1'b1;
                    else          buf_clear_o <= 1'b1;
                end
                data_seen <= 1'b0;
                st        <= ST_IDLE;
                bcnt      <= '0;
                ack_ph    <= 1'b0;
                drive     <= 1'b0;
            end else if (rise && st != ST_IDLE) begin
                wp_seen <= wp_seen | wp_i;
                if (ack_ph) begin
                    mack <= ~sda_i;
                end else begin
                    if (st != ST_RDATA) sh <= {sh[6:0], sda_i};
                    bcnt <= bcnt + 4'd1;
                end
            end else if (fall && st != ST_IDLE) begin
                if (ack_ph) begin
                    ack_ph <= 1'b0;
                    bcnt   <= '0;
                    if (st == ST_RDATA && !mack) begin
                        st    <= ST_IDLE;
                        drive <= 1'b0;
                    end else begin
                        st <= nxt;
                        if (nxt == ST_RDATA) begin
                            sh    <= rd_q_i;
                            drive <= ~rd_q_i[7];
                        end else begin
                            drive <= 1'b0;
                        end
                    end
                end else if (bcnt == 4'd8) begin
                    ack_ph <= 1'b1;
                    mack   <= 1'b0;
                    case (st)
                        ST_DEV: begin
                            if (addr_match && !busy_i) begin
                                drive <= 1'b1;
                                nxt   <= sh[0] ? ST_RDATA : ST_AHI;
                            end else begin
                                drive <= 1'b0;
                                st    <= ST_IDLE;
                            end
                        end
                        ST_AHI: begin
                            hi    <= sh[4:0];
                            drive <= 1'b1;
                            nxt   <= ST_ALO;
                        end
                        ST_ALO: begin
                            ptr         <= ADDR_W'({hi, sh});
                            drive       <= 1'b1;
                            nxt         <= ST_WDATA;
                            data_seen   <= 1'b0;
                            buf_clear_o <= 1'b1;
                        end
                        ST_WDATA: begin
                            buf_we_o   <= 1'b1;
                            buf_off_o  <= ptr[OFF_W-1:0];
                            buf_data_o <= sh;
                            ptr        <= {ptr[ADDR_W-1:OFF_W], ptr[OFF_W-1:0] + OFF_W'(1)};
                            data_seen  <= 1'b1;
                            drive      <= 1'b1;
                            nxt        <= ST_WDATA;
                        end
                        ST_RDATA: begin
                            drive <= 1'b0;
                            ptr   <= ptr + ADDR_W'(1);
                            nxt   <= ST_RDATA;
                        end
                        default: begin
                            drive <= 1'b0;
                            st    <= ST_IDLE;
                        end
                    endcase
                end else if (st == ST_RDATA && bcnt != 4'd0) begin
                    sh    <= {sh[6:0], 1'b0};
                    drive <= ~sh[6];
                end
            end
        end
    end

    assign ptr_o         = ptr;
    assign sda_oe_o      = drive;
    assign commit_base_o = ptr[ADDR_W-1:OFF_W];

    // R3
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= 4'd8);

    // R3
    data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !ack_ph) |-> st == ST_RDATA);

    // R6
    quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> !(st inside {ST_AHI, ST_ALO, ST_WDATA, ST_RDATA}));

    // R9
    wp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> !wp_seen);
endmodule

// File: rtl/eep_slave_engine.sv
// Module: top of the serial EEPROM slave engine.
// Connects the protocol sequencer, the page buffer and the array, and
// combines the external timer busy with the buffer drain into one gate.
// Assumes: an external timer raises busy_i after wr_go_o and holds it for
// the write time; the drain (PAGE cycles) finishes well inside that window.
module eep_slave_engine #(
    parameter int ADDR_W = 11,
    parameter int PAGE   = 32,
    localparam int OFF_W = $clog2(PAGE),
    localparam int BASE_W = ADDR_W - OFF_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic wp_i,
    input  logic sel_i,
    input  logic busy_i,
    output logic sda_oe_o,
    output logic wr_go_o
);
    logic [7:0]        rd_q;
    logic [ADDR_W-1:0] ptr;
    logic              buf_we;
    logic [OFF_W-1:0]  buf_off;
    logic [7:0]        buf_data;
    logic              buf_clear;
    logic              commit;
    logic [BASE_W-1:0] commit_base;
    logic              draining;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_data;
    logic              eng_busy;

    assign eng_busy = busy_i | draining;
    assign wr_go_o  = commit;

    eep_proto #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_proto (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_i),
        .sda_i         (sda_i),
        .start_i       (start_i),
        .stop_i        (stop_i),
        .wp_i          (wp_i),
        .sel_i         (sel_i),
        .busy_i        (eng_busy),
        .rd_q_i        (rd_q),
        .ptr_o         (ptr),
        .buf_we_o      (buf_we),
        .buf_off_o     (buf_off),
        .buf_data_o    (buf_data),
        .buf_clear_o   (buf_clear),
        .commit_o      (commit),
        .commit_base_o (commit_base),
        .sda_oe_o      (sda_oe_o)
    );

    eep_page_buf #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_pbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (buf_we),
        .off_i      (buf_off),
        .data_i     (buf_data),
        .clear_i    (buf_clear),
        .commit_i   (commit),
        .base_i     (commit_base),
        .draining_o (draining),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .mem_data_o (mem_data)
    );

    eep_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_addr),
        .wdata_i (mem_data),
        .raddr_i (ptr),
        .rdata_o (rd_q)
    );
endmodule

// File: tb/sim_eep_slave_engine.sv
// Bench: acts as bus master and write timer, and keeps its own memory and
// pointer model to predict every ACK and read byte.
module sim_eep_slave_engine;
    localparam int AW = 11;
    localparam int DEPTH = 1 << AW;
    localparam int PG = 32;
    localparam int H = 5;
    localparam int BUSY_CYC = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, start_s = 1'b0, stop_s = 1'b0;
    logic wp = 1'b0, sel = 1'b0;
    logic busy;
    logic sda_oe, wr_go;
    logic sda_line;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eep_slave_engine #(.ADDR_W(AW), .PAGE(PG)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .start_i(start_s), .stop_i(stop_s), .wp_i(wp), .sel_i(sel),
        .busy_i(busy), .sda_oe_o(sda_oe), .wr_go_o(wr_go)
    );

    int busy_cnt = 0;
    int go_cnt = 0;
    always @(posedge clk) begin
        if (wr_go) begin
            busy_cnt <= BUSY_CYC;
            go_cnt   <= go_cnt + 1;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end
    assign busy = (busy_cnt != 0);

    int checks = 0, fails = 0;
    logic [7:0] exp_mem [DEPTH];
    bit known [DEPTH];
    int ptr_m = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        if (!scl) begin
            sda_m = 1'b1; tick(H); scl = 1'b1;
        end
        tick(H);
        sda_m = 1'b0; start_s = 1'b1; tick(1); start_s = 1'b0;
        tick(H); scl = 1'b0;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(H); scl = 1'b1; tick(H);
        sda_m = 1'b1; stop_s = 1'b1; tick(1); stop_s = 1'b0;
        tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0;
        end
        sda_m = 1'b1; tick(H); scl = 1'b1; tick(H / 2);
        ack = (sda_line == 1'b0);
        tick(H - H / 2); scl = 1'b0;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        bit stable_ok = 1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            logic v1;
            tick(H); scl = 1'b1; tick(1); v1 = sda_line; tick(H - 1);
            if (v1 !== sda_line) stable_ok = 0;
            b[i] = sda_line; scl = 1'b0;
        end
        check(stable_ok, "R3 data stable while SCL high", 0, 0);
        sda_m = give_ack ? 1'b0 : 1'b1;
        tick(H); scl = 1'b1; tick(H); scl = 1'b0; sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input bit rw);
        return {4'b1010, sel, 2'b00, rw};
    endfunction

    function automatic logic [7:0] hi_byte(input int a);
        logic [7:0] h;
        h = 8'($urandom());
        h[AW-9:0] = a[AW-1:8];
        return h;
    endfunction

    task automatic send_addr(input int a, input string req);
        bit ack;
        send_byte(hi_byte(a), ack); check(ack, req, ack, 1);
        send_byte(8'(a), ack);      check(ack, req, ack, 1);
    endtask

    task automatic poll_ready;
        bit ack = 0;
        for (int k = 0; k < 60 && !ack; k++) begin
            bus_start; send_byte(dev_byte(1'b0), ack); bus_stop;
            if (!ack) tick(20);
        end
        check(ack, "R6 ACK after busy ends", ack, 1);
    endtask

    // Page write of n random bytes at a; wp raised for one byte at wp_at if use_wp.
    task automatic page_write(input int a, input int n, input bit use_wp, input int wp_at);
        bit ack;
        int g0;
        int base = a & ~(PG - 1);
        logic [7:0] d;
        bus_start;
        send_byte(dev_byte(1'b0), ack); check(ack, "R1 write address ACK", ack, 1);
        send_addr(a, "R2 word address ACK");
        ptr_m = a;
        for (int j = 0; j < n; j++) begin
            d = 8'($urandom());
            if (use_wp) wp = (j == wp_at);
            send_byte(d, ack);
            check(ack, use_wp ? "R9 data ACK under protect" : "R4 data ACK", ack, 1);
            if (!use_wp) begin
                exp_mem[base + (ptr_m & (PG - 1))] = d;
                known[base + (ptr_m & (PG - 1))] = 1;
            end
            ptr_m = base + ((ptr_m + 1) & (PG - 1));
        end
        wp = 1'b0;
        g0 = go_cnt;
        bus_stop;
        tick(2);
        if (n > 0 && !use_wp) begin
            check(go_cnt == g0 + 1, "R5 commit pulse", go_cnt - g0, 1);
            bus_start; send_byte(dev_byte(1'b0), ack); bus_stop;
            check(!ack, "R6 NACK while busy", ack, 0);
            poll_ready;
        end else begin
            check(go_cnt == g0, use_wp ? "R9 no commit" : "R7 no commit", go_cnt - g0, 0);
        end
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] b;
        for (int j = 0; j < n; j++) begin
            read_byte(j != n - 1, b);
            if (known[ptr_m]) check(b == exp_mem[ptr_m], req, b, exp_mem[ptr_m]);
            ptr_m = (ptr_m + 1) % DEPTH;
        end
        bus_stop;
        check(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    endtask

    task automatic read_random(input int a, input int n, input string req);
        bit ack;
        bus_start;
        send_byte(dev_byte(1'b0), ack); check(ack, "R1 dummy write ACK", ack, 1);
        send_addr(a, "R2 word address ACK");
        ptr_m = a;
        bus_start;
        send_byte(dev_byte(1'b1), ack); check(ack, "R7 read address ACK", ack, 1);
        read_body(n, req);
    endtask

    task automatic read_current(input int n);
        bit ack;
        bus_start;
        send_byte(dev_byte(1'b1), ack); check(ack, "R7 current read ACK", ack, 1);
        read_body(n, "R7 current read data");
    endtask

    function automatic int region_addr();
        int pg = $urandom_range(0, 4);
        int p = (pg == 4) ? (DEPTH / PG - 1) : pg;
        return p * PG + $urandom_range(0, PG - 1);
    endfunction

    initial begin
        bit ack;
        int a;
        void'($urandom(32'd7341));
        tick(4);
        // R11 reset state
        check(sda_oe == 1'b0, "R11 SDA released in reset", sda_oe, 0);
        check(wr_go == 1'b0, "R11 no commit in reset", wr_go, 0);
        rst_n = 1'b1;
        tick(4);
        check(sda_oe == 1'b0, "R11 SDA released after reset", sda_oe, 0);

        // R1 strap 0: address with bit3 set is refused, then ignored until start
        bus_start;
        send_byte(8'hA8, ack); check(!ack, "R1 mismatch NACK", ack, 0);
        send_byte(8'h00, ack); check(!ack, "R1 ignored after mismatch", ack, 0);
        bus_start;
        send_byte(8'hA0, ack); check(ack, "R1 strap 0 match", ack, 1);
        bus_stop;
        sel = 1'b1;
        bus_start;
        send_byte(8'hA0, ack); check(!ack, "R1 strap 1 refuses 0x50", ack, 0);
        bus_stop;

        // prefill pages 0..3 and the top page (R4, R5)
        for (int p = 0; p < 4; p++) page_write(p * PG, PG, 0, 0);
        page_write(DEPTH - PG, PG, 0, 0);

        // R4 offset wrap within page and overwrite with 34 bytes
        page_write(PG + 30, 5, 0, 0);
        read_current(2);
        page_write(2 * PG + 3, 34, 0, 0);
        read_random(2 * PG, PG, "R4 page contents after overwrite");

        // R6 read address also refused while busy
        page_write(3 * PG + 1, 1, 0, 0);
        page_write(5, 2, 0, 0);
        // page_write polled already; commit again and probe with read direction
        bus_start; send_byte(dev_byte(1'b0), ack); send_addr(9, "R2 word address ACK");
        send_byte(8'h5A, ack); bus_stop;
        exp_mem[9] = 8'h5A; ptr_m = 10;
        bus_start; send_byte(dev_byte(1'b1), ack); bus_stop;
        check(!ack, "R6 read NACK while busy", ack, 0);
        poll_ready;

        // R7 stop after address only loads pointer, no commit
        page_write(3 * PG + 17, 0, 0, 0);
        read_current(3);

        // R8 sequential read wraps from top to 0
        read_random(DEPTH - 2, 5, "R8 sequential wrap");

        // R9 protect high for one byte blocks the whole commit
        page_write(PG + 4, 6, 1, 3);
        read_random(PG, 12, "R9 array unchanged");

        // R10 start + 9 released clocks + start recovers
        read_random(PG + 8, 1, "R7 random read");
        bus_start; send_byte(dev_byte(1'b0), ack); send_byte(8'h00, ack);
        bus_start;
        sda_m = 1'b1;
        for (int k = 0; k < 9; k++) begin
            tick(H); scl = 1'b1; tick(H); scl = 1'b0;
        end
        bus_start;
        send_byte(dev_byte(1'b1), ack); check(ack, "R10 ready after bus reset", ack, 1);
        read_body(2, "R10 pointer kept");

        // R2 upper address bits ignored: random high bits in hi_byte throughout
        read_random(DEPTH - PG + 3, 2, "R2 address truncation");

        // constrained random mix
        for (int it = 0; it < 16; it++) begin
            int kind = $urandom_range(0, 3);
            a = region_addr();
            case (kind)
                0: page_write(a, $urandom_range(1, 12), 0, 0);
                1: page_write(a, $urandom_range(2, 6), 1, $urandom_range(0, 1));
                2: read_random(a, $urandom_range(1, 6), "R8 random sequential read");
                default: read_current($urandom_range(1, 4));
            endcase
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule